// File: doc/BRIEF.md
# Multi-Register Store Sequencer

This block streams the contents of a 32-entry register file into memory for two families of store instruction. The word-block form writes one full 32-bit word per register, from a chosen start register up to the last register. The byte-string form writes a given number of bytes, unpacked from consecutive registers starting at a chosen register. That count comes either from a 5-bit immediate field or from a 7-bit transfer-count field. Register numbering wraps from the last register back to register 0.

The sequencer first forms the effective address. It reads the base register through a single register-file read port and, for the indexed string form, the index register as well. It then issues one write per cycle on a simple memory port that has a valid/ready handshake. It holds each write until the port accepts it. After the final write is accepted, it raises a single-cycle completion pulse. Instruction decode, faults, alignment and caching belong to other blocks.

Top module: `mreg_store_seq`

## Requirements
- R1: Word-block form (`cmd_op` = 0) issues exactly 32 − `cmd_rs` word writes (`mem_word` = 1). Write k carries register (`cmd_rs` + k) whole on `mem_data`. No write follows the one from register 31.
- R2: The base is 0 when `cmd_ra` is 0; otherwise it is the value of register `cmd_ra`. The word-block address is the base plus the sign-extended 16-bit `cmd_disp`. The immediate string (`cmd_op` = 1) address is the base alone.
- R3: Indexed string form (`cmd_op` = 2 or 3) starts at the base plus the value of register `cmd_rb`, and writes `xfer_count` bytes.
- R4: In the immediate string form, `cmd_nb` = 0 selects 32 bytes; any other value selects that many bytes.
- R5: String bytes go most-significant first: bits 31:24, then 23:16, 15:8, 7:0 of each register. Each byte sits in `mem_data[7:0]` with `mem_data[31:8]` zero and `mem_word` = 0. Bytes of a partly used last register beyond the count are not written.
- R6: The string forms use ceil(n/4) consecutive registers from `cmd_rs`, and register 0 follows register 31.
- R7: Addresses rise by 4 per word write and by 1 per byte write. While `mem_valid` is high and `mem_ready` is low, the address, data and size hold unchanged.
- R8: An indexed string store with `xfer_count` = 0 completes with no memory write.
- R9: `done` is high for exactly one cycle, in the cycle after the final write is accepted (or after address formation when there are no writes).
- R10: A command is taken only when `cmd_ready` is high, which is only while idle. `cmd_valid` at any other time, including the `done` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 word block, 1 immediate string, 2/3 indexed string |
| cmd_rs | input | 5 | First source register |
| cmd_ra | input | 5 | Base register number (0 means zero base) |
| cmd_rb | input | 5 | Index register number (indexed string) |
| cmd_disp | input | 16 | Signed displacement (word block) |
| cmd_nb | input | 5 | Immediate byte count, 0 means 32 |
| xfer_count | input | 7 | Byte count for the indexed string form |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 32 | Register-file read data (same cycle) |
| mem_valid | output | 1 | Write request |
| mem_addr | output | 32 | Byte address of the write |
| mem_data | output | 32 | Word, or byte in bits 7:0 |
| mem_word | output | 1 | 1 word write, 0 byte write |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can happen in the same cycle: the completion pulse, and a new command offered on the command port while the sequencer is still finishing. The bench keeps `cmd_valid` high with unrelated fields for the three cycles after acceptance. For the shortest command, an indexed string store with a zero count, this window covers the `done` cycle. The bench then checks that `cmd_ready` stayed low, that no extra write appeared, and that the write stream matched the original command. Random backpressure on `mem_ready` also makes a stalled write fall in the same cycle as these foreign command offers.

// File: rtl/msq_pkg.sv
// Shared types for the multi-register store sequencer.
// Assumes a register file with a combinational read port.
package msq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BASE  = 3'd1,
        ST_INDEX = 3'd2,
        ST_RUN   = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    localparam logic [1:0] OP_WORDS   = 2'd0;
    localparam logic [1:0] OP_STR_IMM = 2'd1;
    // op[1] set selects the indexed string form (codes 2 and 3)
endpackage

// File: rtl/msq_count_init.sv
// Computes the number of transfers for a new command.
// Word block: registers from rs to the last one. Immediate string: nb,
// with 0 meaning the full field range. Indexed string: transfer count.
// Assumes CNT_W is wide enough to hold NREG and 2**NB_W.
module msq_count_init #(
    parameter int NREG   = 32,
    parameter int NB_W   = 5,
    parameter int CNT_W  = 7,
    parameter int RIDX_W = 5
) (
    input  logic [1:0]        op,
    input  logic [RIDX_W-1:0] rs,
    input  logic [NB_W-1:0]   nb,
    input  logic [CNT_W-1:0]  xcount,
    output logic [CNT_W-1:0]  count
);
    import msq_pkg::*;
    localparam logic [CNT_W-1:0] NB_FULL = CNT_W'(1 << NB_W);

    // Select the count source by command kind
    always_comb begin
        if (op[1])
            count = xcount;
        else if (op == OP_STR_IMM)
            count = (nb == '0) ? NB_FULL : CNT_W'(nb);
        else
            count = CNT_W'(NREG) - CNT_W'(rs);
    end
endmodule

// File: rtl/msq_byte_pick.sv
// Forms write data: whole word for word writes, or one byte lane
// (lane 0 = most significant) zero-extended into the low byte.
// Assumes XLEN is a multiple of 8.
module msq_byte_pick #(
    parameter int XLEN   = 32,
    parameter int LANE_W = 2
) (
    input  logic [XLEN-1:0]   word,
    input  logic [LANE_W-1:0] lane,
    input  logic              is_word,
    output logic [XLEN-1:0]   data
);
    localparam int BYTES = XLEN / 8;

    logic [7:0] lanes [BYTES];

    // Slice the word into lanes, most significant byte as lane 0
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lanes[g] = word[XLEN-1-8*g -: 8];
    end

    // Choose full word or the selected lane
    always_comb begin
        if (is_word)
            data = word;
        else
            data = {{(XLEN-8){1'b0}}, lanes[lane]};
    end
endmodule

// File: rtl/mreg_store_seq.sv
// Multi-register store sequencer top. Reads the base (and index)
// register, then streams words or bytes from consecutive registers to
// a valid/ready write port, wrapping register numbers after NREG-1.
// Assumes rf_rdata follows rf_raddr in the same cycle and that the
// register file is not written while a command runs.
module mreg_store_seq #(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int NB_W  = 5,
    parameter int CNT_W = 7,
    parameter int DISP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [$clog2(NREG)-1:0]  cmd_rs,
    input  logic [$clog2(NREG)-1:0]  cmd_ra,
    input  logic [$clog2(NREG)-1:0]  cmd_rb,
    input  logic [DISP_W-1:0]        cmd_disp,
    input  logic [NB_W-1:0]          cmd_nb,
    input  logic [CNT_W-1:0]         xfer_count,
    output logic                     cmd_ready,
    output logic [$clog2(NREG)-1:0]  rf_raddr,
    input  logic [XLEN-1:0]          rf_rdata,
    output logic                     mem_valid,
    output logic [XLEN-1:0]          mem_addr,
    output logic [XLEN-1:0]          mem_data,
    output logic                     mem_word,
    input  logic                     mem_ready,
    output logic                     done
);
    import msq_pkg::*;

    localparam int RIDX_W = $clog2(NREG);
    localparam int BYTES  = XLEN / 8;
    localparam int LANE_W = $clog2(BYTES);
    localparam logic [RIDX_W-1:0] LAST_REG  = RIDX_W'(NREG - 1);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

    seq_state_e          state;
    logic [1:0]          op_q;
    logic [RIDX_W-1:0]   ra_q, rb_q, cur_reg;
    logic [DISP_W-1:0]   disp_q;
    logic [CNT_W-1:0]    left, init_count;
    logic [LANE_W-1:0]   lane;
    logic [XLEN-1:0]     ea, base, offset;
    logic                is_word;

    assign is_word = (op_q == OP_WORDS);

    msq_count_init #(
        .NREG(NREG), .NB_W(NB_W), .CNT_W(CNT_W), .RIDX_W(RIDX_W)
    ) u_count (
        .op(cmd_op), .rs(cmd_rs), .nb(cmd_nb), .xcount(xfer_count),
        .count(init_count)
    );

    msq_byte_pick #(.XLEN(XLEN), .LANE_W(LANE_W)) u_pick (
        .word(rf_rdata), .lane(lane), .is_word(is_word), .data(mem_data)
    );

    // Register-file read address: base, then index, then the data stream
    always_comb begin
        case (state)
            ST_BASE:  rf_raddr = ra_q;
            ST_INDEX: rf_raddr = rb_q;
            default:  rf_raddr = cur_reg;
        endcase
    end

    // Base is zero for register number 0; word block adds the displacement
    always_comb begin
        base   = (ra_q == '0) ? '0 : rf_rdata;
        offset = is_word ? {{(XLEN-DISP_W){disp_q[DISP_W-1]}}, disp_q} : '0;
    end

    assign cmd_ready = (state == ST_IDLE);
    assign mem_valid = (state == ST_RUN);
    assign mem_addr  = ea;
    assign mem_word  = is_word;
    assign done      = (state == ST_DONE);

    // Sequencer state, address, register index and remaining count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= '0;
            ra_q    <= '0;
            rb_q    <= '0;
            cur_reg <= '0;
            disp_q  <= '0;
            left    <= '0;
            lane    <= '0;
            ea      <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    op_q    <= cmd_op;
                    ra_q    <= cmd_ra;
                    rb_q    <= cmd_rb;
                    cur_reg <= cmd_rs;
                    disp_q  <= cmd_disp;
                    left    <= init_count;
                    lane    <= '0;
                    state   <= ST_BASE;
                end
                ST_BASE: begin
                    ea    <= base + offset;
                    state <= op_q[1] ? ST_INDEX : ST_RUN;
                end
                ST_INDEX: begin
                    ea    <= ea + rf_rdata;
                    state <= (left == '0) ? ST_DONE : ST_RUN;
                end
                ST_RUN: if (mem_ready) begin
                    ea   <= ea + (is_word ? XLEN'(BYTES) : XLEN'(1));
                    left <= left - 1'b1;
                    if (is_word || lane == LAST_LANE) begin
                        cur_reg <= (cur_reg == LAST_REG) ? '0 : cur_reg + 1'b1;
                        lane    <= '0;
                    end else begin
                        lane <= lane + 1'b1;
                    end
                    if (left == CNT_W'(1))
                        state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A stalled write keeps address, data and size (R7)
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_data) && $stable(mem_word));

    // Word writes advance the address by the word size (R7)
    assert_word_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready && mem_word |=>
            !mem_valid || mem_addr == $past(mem_addr) + XLEN'(BYTES));

    // Byte writes advance the address by one (R7)
    assert_byte_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready && !mem_word |=>
            !mem_valid || mem_addr == $past(mem_addr) + XLEN'(1));

    // Byte writes carry nothing above the low byte (R5)
    assert_byte_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_word |-> mem_data[XLEN-1:8] == '0);

    // Word block ends with the last register (R1)
    assert_last_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready && mem_word && rf_raddr == LAST_REG |=> !mem_valid);

    // Completion is a single-cycle pulse (R9)
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Completion after a write only once that write was accepted (R9)
    assert_done_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(mem_valid) |-> $past(mem_ready));

    // Ready to take a command only with nothing in flight (R10)
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_valid && !done);
endmodule

// File: tb/mreg_store_seq_tb.sv
// Self-checking bench: random and directed commands with random
// backpressure, compared against expected write lists built here.
module mreg_store_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_rs = '0, cmd_ra = '0, cmd_rb = '0, cmd_nb = '0;
    logic [15:0] cmd_disp = '0;
    logic [6:0]  xfer_count = '0;
    logic        cmd_ready, mem_valid, mem_word, done;
    logic        mem_ready = 1'b0;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata, mem_addr, mem_data;
    logic [31:0] rf [32];

    int checks = 0, errors = 0;
    int exp_n = 0, n_seen = 0, ready_pct = 100;
    bit done_seen = 0, last_acc_edge = 0;
    string cur_tag = "R1";
    logic [31:0] exp_addr [128];
    logic [31:0] exp_data [128];
    logic        exp_word [128];

    always #5 clk = ~clk;

    assign rf_rdata = rf[rf_raddr];

    mreg_store_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rs(cmd_rs), .cmd_ra(cmd_ra), .cmd_rb(cmd_rb), .cmd_disp(cmd_disp),
        .cmd_nb(cmd_nb), .xfer_count(xfer_count), .cmd_ready(cmd_ready),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_word(mem_word),
        .mem_ready(mem_ready), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each accepted write and the completion timing
    always @(posedge clk) begin
        if (rst_n) begin
            if (done) begin
                check(n_seen == exp_n, "R9", "writes before done", n_seen, exp_n);
                check(exp_n == 0 || last_acc_edge, "R9", "done one cycle after last write",
                      last_acc_edge, 1);
                done_seen = 1;
            end
            last_acc_edge = 0;
            if (mem_valid && mem_ready) begin
                if (n_seen < exp_n) begin
                    check(mem_addr == exp_addr[n_seen], cur_tag, "address",
                          mem_addr, exp_addr[n_seen]);
                    check(mem_data == exp_data[n_seen], cur_tag, "data",
                          mem_data, exp_data[n_seen]);
                    check(mem_word == exp_word[n_seen], cur_tag, "size",
                          mem_word, exp_word[n_seen]);
                end else begin
                    check(0, "R8", "unexpected extra write", n_seen, exp_n);
                end
                if (n_seen == exp_n - 1) last_acc_edge = 1;
                n_seen++;
            end
        end
    end

    // Backpressure: ready with probability ready_pct
    always @(negedge clk) mem_ready <= (($urandom % 100) < ready_pct);

    function automatic logic [31:0] sext16(input logic [15:0] d);
        return {{16{d[15]}}, d};
    endfunction

    // Build the expected write list from the requirements
    task automatic build_expected(input logic [1:0] op, input logic [4:0] rs,
                                  input logic [4:0] ra, input logic [4:0] rb,
                                  input logic [15:0] disp, input logic [4:0] nb,
                                  input logic [6:0] xc);
        logic [31:0] base, ea;
        base = (ra == 0) ? 32'd0 : rf[ra];
        if (op == 2'd0) begin
            ea = base + sext16(disp);
            exp_n = 32 - int'(rs);
            for (int i = 0; i < exp_n; i++) begin
                exp_addr[i] = ea + 32'(4 * i);
                exp_data[i] = rf[(int'(rs) + i) % 32];
                exp_word[i] = 1'b1;
            end
        end else begin
            if (op == 2'd1) begin
                ea = base;
                exp_n = (nb == 0) ? 32 : int'(nb);
            end else begin
                ea = base + rf[rb];
                exp_n = int'(xc);
            end
            for (int i = 0; i < exp_n; i++) begin
                logic [31:0] w;
                w = rf[(int'(rs) + i / 4) % 32];
                exp_addr[i] = ea + 32'(i);
                exp_data[i] = {24'd0, w[31 - 8 * (i % 4) -: 8]};
                exp_word[i] = 1'b0;
            end
        end
    endtask

    // Issue one command, optionally offering foreign commands while busy
    task automatic run_cmd(input logic [1:0] op, input logic [4:0] rs,
                           input logic [4:0] ra, input logic [4:0] rb,
                           input logic [15:0] disp, input logic [4:0] nb,
                           input logic [6:0] xc, input bit junk, input string tag);
        int waitc;
        build_expected(op, rs, ra, rb, disp, nb, xc);
        cur_tag = tag;
        n_seen = 0;
        done_seen = 0;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R10", "ready while idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_rs = rs; cmd_ra = ra; cmd_rb = rb;
        cmd_disp = disp; cmd_nb = nb; xfer_count = xc;
        @(negedge clk);
        if (junk) begin
            for (int k = 0; k < 3; k++) begin
                check(cmd_ready == 1'b0, "R10", "not ready while busy", cmd_ready, 0);
                cmd_op = 2'($urandom); cmd_rs = 5'($urandom); cmd_ra = 5'($urandom);
                cmd_rb = 5'($urandom); cmd_disp = 16'($urandom);
                cmd_nb = 5'($urandom); xfer_count = 7'($urandom);
                @(negedge clk);
            end
        end
        cmd_valid = 1'b0;
        waitc = 0;
        while (!done_seen && waitc < 3000) begin
            @(negedge clk);
            waitc++;
        end
        check(done_seen, tag, "command completed", done_seen, 1);
        repeat (2) @(negedge clk);
        check(!mem_valid && !done && cmd_ready, "R10", "quiet after completion",
              {mem_valid, done, cmd_ready}, 3'b001);
        check(n_seen == exp_n, tag, "total writes", n_seen, exp_n);
    endtask

    task automatic fill_rf();
        for (int i = 0; i < 32; i++) rf[i] = $urandom;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        fill_rf();
        repeat (3) @(negedge clk);
        check(cmd_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0, "R10",
              "reset state", {cmd_ready, mem_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        ready_pct = 100;
        run_cmd(2'd0, 5'd31, 5'd3, 5'd0, 16'h0010, 5'd0, 7'd0, 0, "R1");   // single word
        run_cmd(2'd0, 5'd0, 5'd0, 5'd0, 16'hFFF0, 5'd0, 7'd0, 0, "R2");    // zero base, negative disp
        run_cmd(2'd0, 5'd20, 5'd22, 5'd0, 16'h7FFC, 5'd0, 7'd0, 0, "R2");  // base in range
        run_cmd(2'd1, 5'd30, 5'd4, 5'd0, 16'h0, 5'd0, 7'd0, 0, "R4");      // nb 0 -> 32, wraps
        run_cmd(2'd1, 5'd31, 5'd0, 5'd0, 16'h0, 5'd9, 7'd0, 0, "R6");      // wrap to reg 0
        run_cmd(2'd1, 5'd7, 5'd2, 5'd0, 16'h0, 5'd5, 7'd0, 0, "R5");       // partial register
        run_cmd(2'd2, 5'd5, 5'd1, 5'd2, 16'h0, 5'd0, 7'd0, 1, "R8");       // zero count, overlap done
        run_cmd(2'd2, 5'd5, 5'd0, 5'd9, 16'h0, 5'd0, 7'd127, 0, "R3");     // max count, zero base
        run_cmd(2'd3, 5'd28, 5'd6, 5'd6, 16'h0, 5'd0, 7'd7, 1, "R3");      // code 3 indexed
        ready_pct = 40;
        run_cmd(2'd0, 5'd27, 5'd9, 5'd0, 16'h8000, 5'd0, 7'd0, 1, "R7");   // stalls, word
        run_cmd(2'd1, 5'd1, 5'd2, 5'd0, 16'h0, 5'd6, 7'd0, 1, "R7");       // stalls, bytes

        // Constrained random mix
        for (int t = 0; t < 40; t++) begin
            logic [1:0] op;
            fill_rf();
            op = 2'($urandom);
            ready_pct = 30 + int'($urandom % 71);
            run_cmd(op, 5'($urandom), 5'($urandom % 8), 5'($urandom),
                    16'($urandom), 5'($urandom), 7'($urandom % 80),
                    bit'($urandom), (op == 2'd0) ? "R1" : (op == 2'd1) ? "R5" : "R3");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule